// File: doc/BRIEF.md
# Half-Duplex Line Direction Arbiter

This block joins two half-duplex data lines that idle HIGH through pull-ups: one faces the host controller, the other faces the card. Either side may start a transfer by pulling its line LOW. The side that falls first takes the lead. The block then copies that LOW onto the other line once a set number of clock cycles has passed. While the transfer runs, any fall on the following line is ignored.

When the leading side lets go, the block drives the following line HIGH for a short pulse. This speeds up the rising edge. The block then releases both lines and waits for the next fall. If the leading side lets go before the copy delay runs out, the pending LOW is dropped. No pulse is sent and the block goes straight back to waiting.

Both inputs pass through synchronizers before edge detection. Each line's drive is given as two separate enables: one pulls LOW and one pushes HIGH. The copy delay and the pulse width are parameters counted in clock cycles. Together they should stay well under half of a 1 µs line period, so toggling at 1 MHz still works.

Top module: `io_dir_arbiter`

## Requirements
- R1: After reset, and whenever both lines are HIGH with no transfer in progress, all four drive outputs are 0.
- R2: A fall on the host line while idle makes the host the leader: the card line is pulled LOW (card_drv_lo=1) and the host line is never driven.
- R3: A fall on the card line while idle makes the card the leader: host_drv_lo goes to 1 and the card line is never driven.
- R4: If both lines fall in the same sampled cycle, the host side leads.
- R5: During a transfer, a LOW on the following line does not change the leader and does not stop the following line from being held LOW.
- R6: The following line's drive-low enable rises exactly DELAY_CYC+3 clock edges after the leading input falls. This counts SYNC_STAGES=2 synchronizer edges, one detection edge and DELAY_CYC delay edges.
- R7: When the leading input returns HIGH, the drive-low enable drops and the drive-high enable rises on the third clock edge after the change. The drive-high enable stays set for exactly PULSE_CYC cycles and then clears.
- R8: After the pulse, the block is idle again, and the next transfer may run in either direction.
- R9: If the leading input returns HIGH before the delay runs out, no drive-low and no drive-high is ever issued for that fall.
- R10: No line ever has its drive-low and drive-high enables active together, and the two lines are never driven at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_in | input | 1 | Sampled level of the host-side line |
| card_in | input | 1 | Sampled level of the card-side line |
| host_drv_lo | output | 1 | Pull the host line LOW |
| host_drv_hi | output | 1 | Actively push the host line HIGH |
| card_drv_lo | output | 1 | Pull the card line LOW |
| card_drv_hi | output | 1 | Actively push the card line HIGH |

## Verification
Transfers are started from each side in turn. Comparing the two directions shows whether the leader is chosen by the line that moved rather than by a fixed side. A fall on the following line during the delay and during the hold shows whether the lock-out works. Falls on both lines in the same cycle expose the tie-break rule. A LOW pulse that is shorter than the delay separates a cancelled transfer from a completed one. Cycle counts from each input change to the output change pin down the delay and the pulse width.

// File: rtl/io_arb_pkg.sv
package io_arb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DELAY = 2'd1,
    ST_HOLD  = 2'd2,
    ST_PULSE = 2'd3
  } arb_state_e;

  typedef enum logic {
    SIDE_HOST = 1'b0,
    SIDE_CARD = 1'b1
  } side_e;
endpackage

// File: rtl/io_fall_det.sv
module io_fall_det #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic level_o,
  output logic fall_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;
  logic                   prev_q;

  // Shift chain; lines idle HIGH, so reset to 1 to avoid a false fall.
  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        assign sync_d[s] = line_i;
      end else begin : g_next
        assign sync_d[s] = sync_q[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign level_o = sync_q[SYNC_STAGES-1];
  assign fall_o  = prev_q & ~level_o;

  // A detected fall cannot repeat on the next cycle.
  p_fall_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o);
endmodule

// File: rtl/io_arb_timer.sv
module io_arb_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             en_i,
  input  logic [CNT_W-1:0] last_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  assign expired_o = (cnt_q == last_i);

  always_comb begin
    cnt_d = cnt_q;
    if (start_i) begin
      cnt_d = '0;
    end else if (en_i && !expired_o) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // While a window is timed, the count never passes its limit.
  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !start_i) |-> (cnt_q <= last_i));
endmodule

// File: rtl/io_dir_arbiter.sv
module io_dir_arbiter
  import io_arb_pkg::*;
#(
  parameter int unsigned DELAY_CYC   = 8,
  parameter int unsigned PULSE_CYC   = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic host_in,
  input  logic card_in,
  output logic host_drv_lo,
  output logic host_drv_hi,
  output logic card_drv_lo,
  output logic card_drv_hi
);
  localparam int unsigned MAX_CYC = (DELAY_CYC > PULSE_CYC) ? DELAY_CYC : PULSE_CYC;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);
  localparam int unsigned N_LINES = 2;
  localparam logic [CNT_W-1:0] DELAY_LAST = CNT_W'(DELAY_CYC - 1);
  localparam logic [CNT_W-1:0] PULSE_LAST = CNT_W'(PULSE_CYC - 1);

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic [N_LINES-1:0] line_raw;
  logic [N_LINES-1:0] lvl;
  logic [N_LINES-1:0] fall;
  assign line_raw = {card_in, host_in};

  generate
    for (genvar g = 0; g < N_LINES; g++) begin : g_line
      io_fall_det #(.SYNC_STAGES(SYNC_STAGES)) u_det (
        .clk     (clk),
        .rst_n   (rst_sync_n),
        .line_i  (line_raw[g]),
        .level_o (lvl[g]),
        .fall_o  (fall[g])
      );
    end
  endgenerate

  arb_state_e st_q, st_d;
  side_e      mst_q, mst_d;
  logic       tmr_start;
  logic       tmr_en;
  logic       tmr_exp;
  logic [CNT_W-1:0] tmr_last;
  logic       mst_high;

  assign mst_high = (mst_q == SIDE_CARD) ? lvl[1] : lvl[0];
  assign tmr_en   = (st_q == ST_DELAY) || (st_q == ST_PULSE);
  assign tmr_last = (st_q == ST_PULSE) ? PULSE_LAST : DELAY_LAST;

  io_arb_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .start_i   (tmr_start),
    .en_i      (tmr_en),
    .last_i    (tmr_last),
    .expired_o (tmr_exp)
  );

  // Next-state logic
  always_comb begin
    st_d      = st_q;
    mst_d     = mst_q;
    tmr_start = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (fall[0]) begin
          mst_d = SIDE_HOST;  st_d = ST_DELAY;  tmr_start = 1'b1;
        end else if (fall[1]) begin
          mst_d = SIDE_CARD;  st_d = ST_DELAY;  tmr_start = 1'b1;
        end
      end
      ST_DELAY: begin
        if (mst_high)     st_d = ST_IDLE;
        else if (tmr_exp) st_d = ST_HOLD;
      end
      ST_HOLD: begin
        if (mst_high) begin
          st_d = ST_PULSE;  tmr_start = 1'b1;
        end
      end
      ST_PULSE: begin
        if (tmr_exp) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      st_q  <= ST_IDLE;
      mst_q <= SIDE_HOST;
    end else begin
      st_q  <= st_d;
      mst_q <= mst_d;
    end
  end

  assign card_drv_lo = (st_q == ST_HOLD)  && (mst_q == SIDE_HOST);
  assign card_drv_hi = (st_q == ST_PULSE) && (mst_q == SIDE_HOST);
  assign host_drv_lo = (st_q == ST_HOLD)  && (mst_q == SIDE_CARD);
  assign host_drv_hi = (st_q == ST_PULSE) && (mst_q == SIDE_CARD);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (st_q == ST_IDLE) |-> !(host_drv_lo || host_drv_hi || card_drv_lo || card_drv_hi));

  p_host_wins_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (st_q == ST_IDLE && fall[0] && fall[1]) |=> (mst_q == SIDE_HOST));

  p_lockout_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (st_q != ST_IDLE) |=> (st_q == ST_IDLE || $stable(mst_q)));

  p_delay_full_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (st_q == ST_DELAY && !tmr_exp) |=> (st_q != ST_HOLD));

  p_pulse_follows_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (st_q == ST_HOLD) |=> (st_q == ST_HOLD || st_q == ST_PULSE));

  p_cancel_no_pulse_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (st_q == ST_DELAY) |=> (st_q != ST_PULSE));

  p_no_contend_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(host_drv_lo && host_drv_hi) && !(card_drv_lo && card_drv_hi) &&
    !((host_drv_lo || host_drv_hi) && (card_drv_lo || card_drv_hi)));
endmodule

// File: tb/io_dir_arbiter_tb_top.sv
module io_dir_arbiter_tb_top;
  localparam int unsigned D = 8;
  localparam int unsigned P = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_ext_lo = 1'b0;
  logic card_ext_lo = 1'b0;
  logic host_in, card_in;
  logic host_drv_lo, host_drv_hi, card_drv_lo, card_drv_hi;

  int checks = 0;
  int fails  = 0;
  int contend_cycles = 0;

  always #2 clk = ~clk;

  // Open-drain line model: LOW if anyone pulls it down.
  assign host_in = !(host_drv_lo || host_ext_lo);
  assign card_in = !(card_drv_lo || card_ext_lo);

  io_dir_arbiter #(.DELAY_CYC(D), .PULSE_CYC(P), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_in(host_in), .card_in(card_in),
    .host_drv_lo(host_drv_lo), .host_drv_hi(host_drv_hi),
    .card_drv_lo(card_drv_lo), .card_drv_hi(card_drv_hi)
  );

  always @(negedge clk) begin
    if ((host_drv_lo && host_drv_hi) || (card_drv_lo && card_drv_hi) ||
        ((host_drv_lo || host_drv_hi) && (card_drv_lo || card_drv_hi)))
      contend_cycles++;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int drv_word();
    return {host_drv_lo, host_drv_hi, card_drv_lo, card_drv_hi};
  endfunction

  // One full transfer. card_lead picks the leader; poke drops the following
  // line during the delay; both makes the two lines fall together.
  task automatic run_xfer(input bit card_lead, input bit poke, input bit both,
                          input string req);
    int  lat = -1;
    int  first_hi = -1;
    int  width = 0;
    bit  lead_driven = 1'b0;
    bit  lo_stuck = 1'b0;
    if (card_lead) card_ext_lo = 1'b1; else host_ext_lo = 1'b1;
    if (both) begin
      if (card_lead) host_ext_lo = 1'b1; else card_ext_lo = 1'b1;
    end
    for (int i = 1; i <= int'(D) + 6; i++) begin
      tick();
      if (poke && i == 4) begin
        if (card_lead) host_ext_lo = 1'b1; else card_ext_lo = 1'b1;
      end
      if (lat < 0 && (card_lead ? host_drv_lo : card_drv_lo)) lat = i;
      if (card_lead ? (card_drv_lo || card_drv_hi) : (host_drv_lo || host_drv_hi))
        lead_driven = 1'b1;
    end
    check(lat == int'(D) + 3, req, "cycles to follower drive-low (R6)", lat, D + 3);
    if (poke || both) begin
      if (card_lead) host_ext_lo = 1'b0; else card_ext_lo = 1'b0;
      repeat (3) tick();
      check((card_lead ? host_drv_lo : card_drv_lo) == 1'b1, req,
            "follower still held LOW after its own LOW (R5)",
            int'(card_lead ? host_drv_lo : card_drv_lo), 1);
    end
    if (card_lead) card_ext_lo = 1'b0; else host_ext_lo = 1'b0;
    for (int i = 1; i <= int'(P) + 8; i++) begin
      tick();
      if (card_lead ? host_drv_hi : card_drv_hi) begin
        if (first_hi < 0) first_hi = i;
        width++;
      end
      if (i >= 3 && (card_lead ? host_drv_lo : card_drv_lo)) lo_stuck = 1'b1;
      if (card_lead ? (card_drv_lo || card_drv_hi) : (host_drv_lo || host_drv_hi))
        lead_driven = 1'b1;
    end
    check(first_hi == 3, req, "cycles to pulse start (R7)", first_hi, 3);
    check(width == int'(P), req, "pulse width (R7)", width, P);
    check(!lo_stuck, req, "drive-low cleared at pulse (R7)", int'(lo_stuck), 0);
    check(!lead_driven, req, "leader line never driven", int'(lead_driven), 0);
    check(drv_word() == 0, req, "idle after pulse (R8)", drv_word(), 0);
  endtask

  task automatic t_reset();
    check(drv_word() == 0, "R1", "drives after reset", drv_word(), 0);
    repeat (5) tick();
    check(drv_word() == 0, "R1", "drives while both HIGH", drv_word(), 0);
  endtask

  task automatic t_host_lead();
    run_xfer(1'b0, 1'b0, 1'b0, "R2");
  endtask

  task automatic t_card_lead();
    run_xfer(1'b1, 1'b0, 1'b0, "R3");   // follows a host transfer: R8
  endtask

  task automatic t_lockout();
    run_xfer(1'b0, 1'b1, 1'b0, "R5");
  endtask

  task automatic t_tie();
    run_xfer(1'b0, 1'b0, 1'b1, "R4");
  endtask

  task automatic t_cancel();
    int seen = 0;
    host_ext_lo = 1'b1;
    tick(); tick();
    host_ext_lo = 1'b0;
    for (int i = 0; i < 24; i++) begin
      tick();
      if (drv_word() != 0) seen++;
    end
    check(seen == 0, "R9", "drive cycles after short LOW", seen, 0);
    run_xfer(1'b1, 1'b0, 1'b0, "R8");
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();
    t_reset();
    t_host_lead();
    repeat (4) tick();
    t_card_lead();
    repeat (4) tick();
    t_lockout();
    repeat (4) tick();
    t_tie();
    repeat (4) tick();
    t_cancel();
    repeat (4) tick();
    check(contend_cycles == 0, "R10", "cycles with conflicting drives", contend_cycles, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule